// File: doc/BRIEF.md
# Framer Severely Errored Frame Monitor

This block watches the receive side of one T1/E1 framer channel and keeps two performance counts. Once per received frame the framer pulses a strobe. With the strobe come a flag that marks the framing pattern of that frame as errored, a line-mode select and a loss-of-frame indication. The first count is a 16-bit total of errored framing patterns. The second is an 8-bit total of severely errored frame events. An event is a run of consecutive errored framing patterns whose required length depends on the line mode.

Software reaches both counts through a byte-wide read port. Every readable count returns what has built up since its last read and is then cleared. Reading the low byte of the 16-bit count also captures its high byte, so the two halves of one reading always belong together. Both counts stop at all-ones and do not wrap. A framing error that arrives in the same cycle as a clearing read is kept as a count of one.

Top module: `sefm_top`

## Requirements
- R1: After reset, reads at addresses 0, 1 and 2 all return 0.
- R2: The framing error count rises by exactly one for each cycle with frame_stb=1 and fa_err=1. It does not change while frame_stb is 0, even if fa_err is 1.
- R3: The framing error count stops at 16'hFFFF and the severely errored frame count stops at 8'hFF. Neither wraps.
- R4: A read at address 0 returns bits 7:0 of the framing error count, copies bits 15:8 into a holding byte and clears the count. A read at address 1 returns the holding byte and then clears it.
- R5: When a clearing read of a count happens in the same cycle as an event for that count, the count becomes 1 after that cycle.
- R6: With mode 2'b00 (superframe), errored framing bits in 6 consecutive frames give one severely errored frame event.
- R7: With mode 2'b01 (extended superframe), errored framing bits in 24 consecutive frames give one event.
- R8: With mode 2'b10 or 2'b11 (E1), two consecutive errored alignment signals give one event. No event is counted if lof is 1 on the frame that completes the pair.
- R9: A frame with a good framing bit restarts the run. Every completed run, whether counted or suppressed, also restarts the run, so a continuing error stream gives one event per full window.
- R10: A change of mode restarts the run but leaves both counts unchanged.
- R11: A read at address 2 returns the severely errored frame count and then clears it. A read at address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One pulse per received frame |
| fa_err | input | 1 | Framing pattern of this frame is errored (valid with frame_stb) |
| lof | input | 1 | Loss-of-frame condition declared |
| mode | input | 2 | 00 superframe, 01 extended superframe, 1x E1 |
| rd_en | input | 1 | Register read strobe; the addressed count is cleared at the clock edge |
| rd_addr | input | 2 | 0 error count low, 1 held high byte, 2 severe count, 3 unused |
| rd_data | output | 8 | Read data, valid in the same cycle as rd_en |

## Verification
The bench sweeps every run length from zero up to just past two windows in each of the three modes. It expects floor(length/window) events, so a design that is off by one in the threshold, or that keeps counting inside a run without restarting it, gives the wrong total. The bench pushes more than 65535 errors to reach both saturation points, where a counter that wraps would read back a small value. It puts a read and an event in the same cycle, where a design that drops the event reads back 0. It breaks a run with a mode change, which shows whether a design keeps a stale run length or wipes the counts. Loss of frame on the second E1 error must suppress the event without leaving a half-run behind.

// File: rtl/sefm_pkg.sv
package sefm_pkg;

    typedef enum logic [1:0] {
        MODE_SF     = 2'b00,
        MODE_ESF    = 2'b01,
        MODE_E1     = 2'b10,
        MODE_E1_ALT = 2'b11
    } frm_mode_e;

    localparam logic [1:0] ADDR_FA_LO = 2'd0;
    localparam logic [1:0] ADDR_FA_HI = 2'd1;
    localparam logic [1:0] ADDR_SEF   = 2'd2;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sefm_sat_counter.sv
module sefm_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = inc ? W'(1) : '0;
        end else if (inc && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    // R3: a full counter stays full until cleared
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && !clr) |=> count == CNT_MAX);

    // R5: an event that meets a clearing read survives as one
    a_r5_clear_keeps_event: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> count == W'(1));

    // R2: one step per event below the ceiling
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && count != CNT_MAX) |=> count == $past(count) + W'(1));

    // R2: no event, no clear, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(count));

endmodule

// File: rtl/sefm_run_tracker.sv
module sefm_run_tracker #(
    parameter int SF_LEN  = 6,
    parameter int ESF_LEN = 24,
    parameter int E1_LEN  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_stb,
    input  logic       fa_err,
    input  logic       lof,
    input  logic [1:0] mode,
    output logic       sef_evt
);
    import sefm_pkg::*;

    localparam int LMAX  = max3(SF_LEN, ESF_LEN, E1_LEN);
    localparam int RUN_W = $clog2(LMAX + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic [1:0]       mode;
    } trk_st_t;

    trk_st_t          st_d, st_q;
    logic [RUN_W-1:0] limit;
    logic [RUN_W-1:0] base;
    logic [RUN_W-1:0] nxt;
    logic             is_e1;

    always_comb begin
        unique case (frm_mode_e'(mode))
            MODE_SF:  limit = RUN_W'(SF_LEN);
            MODE_ESF: limit = RUN_W'(ESF_LEN);
            default:  limit = RUN_W'(E1_LEN);
        endcase
        is_e1   = mode[1];
        base    = (mode != st_q.mode) ? '0 : st_q.run;
        nxt     = base + RUN_W'(1);
        st_d    = st_q;
        st_d.mode = mode;
        st_d.run  = base;
        sef_evt = 1'b0;
        if (frame_stb) begin
            if (!fa_err) begin
                st_d.run = '0;
            end else if (nxt == limit) begin
                st_d.run = '0;
                sef_evt  = !(is_e1 && lof);
            end else begin
                st_d.run = nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: an event only ever comes from an errored frame strobe
    a_r6_evt_needs_err: assert property (@(posedge clk) disable iff (!rst_n)
        sef_evt |-> (frame_stb && fa_err));

    // R9: a good framing bit restarts the run
    a_r9_good_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !fa_err) |=> st_q.run == '0);

    // R9: the run never reaches the longest window
    a_r9_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run < RUN_W'(LMAX));

    // R10: a mode change with no strobe leaves an empty run
    a_r10_mode_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != st_q.mode && !frame_stb) |=> st_q.run == '0);

endmodule

// File: rtl/sefm_top.sv
module sefm_top #(
    parameter int FA_W    = 16,
    parameter int SEF_W   = 8,
    parameter int SF_LEN  = 6,
    parameter int ESF_LEN = 24,
    parameter int E1_LEN  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_stb,
    input  logic       fa_err,
    input  logic       lof,
    input  logic [1:0] mode,
    input  logic       rd_en,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data
);
    import sefm_pkg::*;

    localparam int HI_W = FA_W - 8;

    typedef struct packed {
        logic [7:0] hold;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [FA_W-1:0]  fa_cnt;
    logic [SEF_W-1:0] sef_cnt;
    logic             sef_evt;
    logic             fa_evt;
    logic             fa_clr;
    logic             sef_clr;

    assign fa_evt  = frame_stb && fa_err;
    assign fa_clr  = rd_en && rd_addr == ADDR_FA_LO;
    assign sef_clr = rd_en && rd_addr == ADDR_SEF;

    sefm_run_tracker #(
        .SF_LEN (SF_LEN),
        .ESF_LEN(ESF_LEN),
        .E1_LEN (E1_LEN)
    ) i_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_stb(frame_stb),
        .fa_err   (fa_err),
        .lof      (lof),
        .mode     (mode),
        .sef_evt  (sef_evt)
    );

    sefm_sat_counter #(.W(FA_W)) i_fa_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (fa_clr),
        .inc  (fa_evt),
        .count(fa_cnt)
    );

    sefm_sat_counter #(.W(SEF_W)) i_sef_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (sef_clr),
        .inc  (sef_evt),
        .count(sef_cnt)
    );

    always_comb begin
        st_d = st_q;
        if (fa_clr) begin
            st_d.hold = 8'(fa_cnt[FA_W-1:8]);
        end else if (rd_en && rd_addr == ADDR_FA_HI) begin
            st_d.hold = '0;
        end
        rd_data = '0;
        if (rd_en) begin
            unique case (rd_addr)
                ADDR_FA_LO: rd_data = fa_cnt[7:0];
                ADDR_FA_HI: rd_data = st_q.hold;
                ADDR_SEF:   rd_data = 8'(sef_cnt);
                default:    rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: reading the low byte captures the high byte of that same count
    a_r4_hold_latch: assert property (@(posedge clk) disable iff (!rst_n)
        fa_clr |=> st_q.hold == 8'($past(fa_cnt[FA_W-1:8])));

    // R4: the live count restarts after a low-byte read
    a_r4_low_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (fa_clr && !fa_evt) |=> fa_cnt == '0);

    // R11: unused address reads zero
    a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == 2'd3) |-> rd_data == 8'd0);

    initial begin
        a_fa_width: assert (HI_W >= 1 && HI_W <= 8);
    end

endmodule

// File: tb/test_sefm_top.sv
module test_sefm_top;
    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic       fa_err = 1'b0;
    logic       lof = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    sefm_top i_sefm_top (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .fa_err(fa_err),
        .lof(lof), .mode(mode), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic drive(input logic stb, input logic err, input logic l,
                         input logic rd, input logic [1:0] a);
        @(negedge clk);
        frame_stb = stb; fa_err = err; lof = l; rd_en = rd; rd_addr = a;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    endtask

    task automatic frame(input logic err, input logic l);
        drive(1'b1, err, l, 1'b0, 2'd0);
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        drive(1'b0, 1'b0, 1'b0, 1'b1, a);
        #1 v = int'(rd_data);
    endtask

    task automatic rd_fa(output int v);
        int lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        idle();
        v = hi * 256 + lo;
    endtask

    task automatic rd_sef(output int v);
        rd(2'd2, v);
        idle();
    endtask

    function automatic int win(input logic [1:0] m);
        return (m == 2'b00) ? 6 : (m == 2'b01) ? 24 : 2;
    endfunction

    initial begin
        #(CLK_PER * 190000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk("R1 addr0", v, 0);
        rd(2'd1, v); chk("R1 addr1", v, 0);
        rd(2'd2, v); chk("R1 addr2", v, 0);
        rd(2'd3, v); chk("R11 addr3", v, 0);
        idle();

        // R2 error without strobe is ignored
        drive(1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
        idle();
        rd_fa(v); chk("R2 no strobe", v, 0);

        // R6 R7 R8 R9 sweep run lengths per mode
        for (int mi = 0; mi < 3; mi++) begin
            logic [1:0] m;
            m = 2'(mi);
            drive(1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
            mode = m;
            idle(); idle();
            for (int len = 0; len <= 2 * win(m) + 1; len++) begin
                int fa, sef;
                for (int k = 0; k < len; k++) frame(1'b1, 1'b0);
                frame(1'b0, 1'b0);
                frame(1'b0, 1'b0);
                idle();
                rd_fa(fa);
                rd_sef(sef);
                chk($sformatf("R2 fa mode%0d len%0d", mi, len), fa, len);
                chk($sformatf("R6 R7 R8 R9 sef mode%0d len%0d", mi, len), sef, len / win(m));
            end
        end

        // R9 broken runs in SF: 5 errors, good, 5 errors -> no event
        mode = 2'b00; idle(); idle();
        for (int k = 0; k < 5; k++) frame(1'b1, 1'b0);
        frame(1'b0, 1'b0);
        for (int k = 0; k < 5; k++) frame(1'b1, 1'b0);
        idle();
        rd_sef(v); chk("R9 broken run", v, 0);
        rd_fa(v); chk("R2 broken run fa", v, 10);

        // R8 lof suppression in E1, run restarts after suppressed pair
        mode = 2'b10; idle(); idle();
        frame(1'b1, 1'b0); frame(1'b1, 1'b1);
        frame(1'b1, 1'b0);
        idle();
        rd_sef(v); chk("R8 lof suppress", v, 0);
        frame(1'b1, 1'b0);
        idle();
        rd_sef(v); chk("R8 after lof", v, 1);
        mode = 2'b11; idle(); idle();
        frame(1'b1, 1'b0); frame(1'b1, 1'b0);
        idle();
        rd_sef(v); chk("R8 mode 11", v, 1);
        rd_fa(v);

        // R10 mode change restarts run, keeps counts
        mode = 2'b00; idle(); idle();
        for (int k = 0; k < 5; k++) frame(1'b1, 1'b0);
        idle(); mode = 2'b01; idle(); idle(); mode = 2'b00; idle(); idle();
        frame(1'b1, 1'b0);
        idle();
        rd_sef(v); chk("R10 run restarted", v, 0);
        for (int k = 0; k < 5; k++) frame(1'b1, 1'b0);
        idle();
        rd_sef(v); chk("R10 new window", v, 1);
        rd_fa(v); chk("R10 counts kept", v, 11);

        // R5 read and event in same cycle
        frame(1'b1, 1'b0); frame(1'b1, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 2'd0);
        #1 chk("R5 fa read value", int'(rd_data), 2);
        idle();
        rd_fa(v); chk("R5 fa kept event", v, 1);
        mode = 2'b10; idle(); idle();
        frame(1'b1, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 2'd2);
        #1 chk("R5 sef read value", int'(rd_data), 0);
        idle();
        rd_sef(v); chk("R5 sef kept event", v, 1);
        rd_fa(v);

        // R4 coherent high byte: 300 errors then low read, errors, high read
        for (int k = 0; k < 300; k++) frame(1'b0, 1'b0);
        for (int k = 0; k < 300; k++) frame(1'b1, 1'b0);
        idle();
        rd(2'd0, v); chk("R4 low byte", v, 300 % 256);
        for (int k = 0; k < 260; k++) frame(1'b1, 1'b0);
        rd(2'd1, v); chk("R4 held high byte", v, 300 / 256);
        rd(2'd1, v); chk("R4 hold cleared", v, 0);
        idle();
        rd_fa(v); chk("R4 live count cleared", v, 260);
        rd_sef(v);

        // R3 saturation of both counts
        for (int k = 0; k < 65540; k++) frame(1'b1, 1'b0);
        idle();
        rd_fa(v); chk("R3 fa saturates", v, 65535);
        rd_sef(v); chk("R3 sef saturates", v, 255);
        rd_sef(v); chk("R11 sef cleared", v, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule